// File: doc/BRIEF.md
# Input Overvoltage Protection Sequencer

This block is the digital control core of an input-voltage protection switch. Two comparator results arrive already synchronized to the clock. One is high when the supply is under its lower limit, the other when it is over its upper limit. An enable pin, active low, also comes in. The block drives a gate-enable line that starts the charge pump for an external pass transistor, and an active-low fault flag for the host. The comparators, the pump and the open-drain stage sit outside the block.

The supply has to be in the valid window with enable low for a full qualification interval before the gate turns on. After the gate turns on, the flag stays low for a blanking interval and only then releases. Both intervals are parameters counted in clock cycles, and each defaults to 50 ms at 50 MHz. Any fault or disable turns the gate off in the same cycle and sends the sequence back to the start. The control pins are plain levels with no handshake.

Top module: `ovp_sequencer`

## Requirements
- R1: While reset is held and at the first sample after it is released, with valid inputs and enable low, gate_en_o is 0 and fault_n_o is 0. Reset is synchronous and active high.
- R2: Whenever uv_i is 1, gate_en_o is 0 and fault_n_o is 0 in that same cycle, in every state, with no added latency.
- R3: Whenever ov_i is 1, gate_en_o is 0 and fault_n_o is 0 in that same cycle, in every state, with no delay and no blanking.
- R4: en_n_i = 1 forces gate_en_o to 0 in the same cycle. With no fault present, fault_n_o then reads 1. With uv_i or ov_i also at 1, fault_n_o reads 0, so the enable pin never hides a fault.
- R5: The inputs become valid (uv_i = 0, ov_i = 0, en_n_i = 0) just before rising edge 1. From then, gate_en_o stays 0 through edge QUAL_CYCLES and reads 1 after edge QUAL_CYCLES+1.
- R6: After the gate turns on, fault_n_o stays 0 for BLANK_CYCLES more edges. It reads 1 after edge QUAL_CYCLES+BLANK_CYCLES+1.
- R7: A fault or a disable at any point in qualification or blanking sends the block back to its off state. Once the inputs are valid again, the full qualification and blanking sequence of R5 and R6 is needed again.
- R8: Leaving the on state for any cause, whether undervoltage, overvoltage or disable, also needs the full R5/R6 sequence before the gate and the flag return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| uv_i | input | 1 | Synchronized comparator: 1 = supply below the lower limit |
| ov_i | input | 1 | Synchronized comparator: 1 = supply above the upper limit |
| en_n_i | input | 1 | Enable, active low; 1 forces the gate off |
| gate_en_o | output | 1 | 1 = run the charge pump and turn the pass device on |
| fault_n_o | output | 1 | Fault flag, active low |

## Verification
Gate removal and flag assertion take effect in the cycle a fault or a disable appears. The bench checks them a moment after it changes the inputs, with no clock edge in between. Turn-on is counted in rising edges from the first valid sample. The gate is due after edge QUAL_CYCLES+1 and the flag release after edge QUAL_CYCLES+BLANK_CYCLES+1. The bench samples both outputs at every falling edge along that path and compares each sample with the edge count. A sweep injects each fault cause at every edge offset inside qualification and blanking, then times the next full sequence the same way.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_QUAL  = 2'd1,
    ST_BLANK = 2'd2,
    ST_ON    = 2'd3
  } ovp_state_e;
endpackage

// File: rtl/ovp_interval_timer.sv
module ovp_interval_timer #(
  parameter int LEN = 2_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] count;

  assign done = run && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) count <= '0;
    else if (count != LAST) count <= count + 1'b1;
  end

  // R5: the count never passes the last value of the interval
  assert_count_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    count <= LAST);
endmodule

// File: rtl/ovp_state_ctrl.sv
module ovp_state_ctrl
  import ovp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       uv,
  input  logic       ov,
  input  logic       en_n,
  input  logic       qual_done,
  input  logic       blank_done,
  output ovp_state_e state
);
  ovp_state_e nxt;
  logic       valid;

  assign valid = !uv && !ov && !en_n;

  always_comb begin
    nxt = state;
    if (!valid) nxt = ST_OFF;
    else begin
      unique case (state)
        ST_OFF:   nxt = ST_QUAL;
        ST_QUAL:  if (qual_done)  nxt = ST_BLANK;
        ST_BLANK: if (blank_done) nxt = ST_ON;
        ST_ON:    nxt = ST_ON;
        default:  nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else     state <= nxt;
  end

  assert_reset_off_R1: assert property (@(posedge clk)
    rst |=> state == ST_OFF);
  assert_uv_drops_R2: assert property (@(posedge clk) disable iff (rst)
    uv |=> state == ST_OFF);
  assert_ov_drops_R3: assert property (@(posedge clk) disable iff (rst)
    ov |=> state == ST_OFF);
  assert_disable_drops_R4: assert property (@(posedge clk) disable iff (rst)
    en_n |=> state == ST_OFF);
  assert_full_qualify_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BLANK && $past(state) == ST_QUAL) |-> $past(qual_done));
  assert_full_blank_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ON && $past(state) == ST_BLANK) |-> $past(blank_done));
endmodule

// File: rtl/ovp_sequencer.sv
module ovp_sequencer
  import ovp_pkg::*;
#(
  parameter int QUAL_CYCLES  = 2_500_000,
  parameter int BLANK_CYCLES = 2_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_i,
  input  logic ov_i,
  input  logic en_n_i,
  output logic gate_en_o,
  output logic fault_n_o
);
  ovp_state_e state;
  logic       qual_done;
  logic       blank_done;
  logic       fault;

  ovp_interval_timer #(.LEN(QUAL_CYCLES)) i_qual_timer (
    .clk(clk), .rst(rst), .run(state == ST_QUAL), .done(qual_done)
  );

  ovp_interval_timer #(.LEN(BLANK_CYCLES)) i_blank_timer (
    .clk(clk), .rst(rst), .run(state == ST_BLANK), .done(blank_done)
  );

  ovp_state_ctrl i_ctrl (
    .clk(clk), .rst(rst), .uv(uv_i), .ov(ov_i), .en_n(en_n_i),
    .qual_done(qual_done), .blank_done(blank_done), .state(state)
  );

  assign fault     = uv_i || ov_i;
  assign gate_en_o = (state == ST_BLANK || state == ST_ON) && !fault && !en_n_i && !rst;
  assign fault_n_o = !fault && !rst && (state == ST_ON || en_n_i);

  // R6: the flag never releases while the gate is in its blanking phase
  assert_flag_held_in_blank_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BLANK && !en_n_i) |-> !fault_n_o);
endmodule

// File: tb/test_ovp_sequencer.sv
module test_ovp_sequencer;
  localparam int QUAL  = 5;
  localparam int BLANK = 3;

  logic clk = 0;
  logic rst = 1;
  logic uv = 0, ov = 0, en_n = 0;
  logic gate, flag_n;
  int   checks = 0;
  int   errors = 0;

  always #10 clk = ~clk;

  ovp_sequencer #(.QUAL_CYCLES(QUAL), .BLANK_CYCLES(BLANK)) i_ovp_sequencer (
    .clk(clk), .rst(rst), .uv_i(uv), .ov_i(ov), .en_n_i(en_n),
    .gate_en_o(gate), .fault_n_o(flag_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_in(input logic u, input logic o, input logic e);
    uv = u; ov = o; en_n = e;
    #1;
  endtask

  // Inputs are valid now and the block is off; walk the full turn-on.
  task automatic run_seq(input string req);
    for (int n = 0; n <= QUAL + BLANK + 2; n++) begin
      check({req, " R5 gate"}, gate,   n >= QUAL + 1);
      check({req, " R6 flag"}, flag_n, n >= QUAL + BLANK + 1);
      @(negedge clk); #1;
    end
  endtask

  task automatic force_off();
    set_in(1, 0, 0);
    repeat (2) @(negedge clk);
    set_in(0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 gate in reset", gate, 0);
    check("R1 flag in reset", flag_n, 0);
    rst = 0; #1;
    check("R1 gate after reset", gate, 0);
    check("R1 flag after reset", flag_n, 0);
    run_seq("R1 first");

    // R3: overvoltage in the on state
    set_in(0, 1, 0);
    check("R3 gate", gate, 0);
    check("R3 flag", flag_n, 0);
    repeat (2) @(negedge clk); #1;
    check("R3 gate held", gate, 0);
    set_in(0, 0, 0);
    run_seq("R8 after ov");

    // R2: undervoltage in the on state
    set_in(1, 0, 0);
    check("R2 gate", gate, 0);
    check("R2 flag", flag_n, 0);
    repeat (2) @(negedge clk); #1;
    check("R2 flag held", flag_n, 0);
    set_in(0, 0, 0);
    run_seq("R8 after uv");

    // R4: disable in the on state, then a fault under disable
    set_in(0, 0, 1);
    check("R4 gate", gate, 0);
    check("R4 flag clear", flag_n, 1);
    @(negedge clk); set_in(1, 0, 1);
    check("R4 uv not hidden", flag_n, 0);
    @(negedge clk); set_in(0, 1, 1);
    check("R4 ov not hidden", flag_n, 0);
    @(negedge clk); set_in(0, 0, 1);
    check("R4 flag clear again", flag_n, 1);
    check("R4 gate still off", gate, 0);
    @(negedge clk); set_in(0, 0, 0);
    run_seq("R8 after disable");

    // R7: each cause at every offset within qualification and blanking
    for (int cause = 0; cause < 3; cause++) begin
      for (int j = 1; j <= QUAL + BLANK; j++) begin
        force_off();
        repeat (j) @(negedge clk);
        #1;
        check("R7 gate before cause", gate, j >= QUAL + 1);
        check("R7 flag before cause", flag_n, 0);
        set_in(cause == 0, cause == 1, cause == 2);
        check("R7 gate on cause", gate, 0);
        check("R7 flag on cause", flag_n, cause == 2);
        repeat (2) @(negedge clk);
        set_in(0, 0, 0);
        run_seq("R7 restart");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule